// File: doc/BRIEF.md
# Periodic Battery Health Test Scheduler

This block decides when a backup battery is put under load and what the system is told about its health. A seconds tick paces two timers. One timer spaces the tests a long interval apart. The other sets the length of the load window. A digital comparator flag reports whether the battery sits above its trip point, and the block samples it through a synchronizer while the test load is connected. At the end of the window the result is latched onto an active-low warning output. That output behaves like an open-drain pin: it only ever pulls low.

The block starts working once a supply supervisor reports that recovery after supply-valid is complete. The first thing it does then is a power-up test. After that it tests periodically, once per full interval. A power failure suspends everything: the load is removed at once and the warning holds its value. The warning is sticky across periodic tests, because a periodic pass does not clear it. The power-up test, by contrast, re-evaluates the warning from scratch. A good power-up result clears it and periodic testing resumes.

All pins are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `batt_test_sched`

## Requirements
- R1: After reset, `load_en` is 0 and `warn_n` is 1 (released).
- R2: No test starts while `rec_done` is 0, whatever `sec_tick` does. In the first cycle in which `rec_done`=1 and `pwr_fail`=0, a power-up test is registered, and `load_en` is 1 from the following cycle.
- R3: `load_en` stays 1 through a window. The window ends at the clock edge that sees the PULSE_S-th `sec_tick` pulse after the window opened, and `load_en` is 0 after that edge.
- R4: `batt_above_trip`=1 means the battery is healthy. The flag passes through a SYNC_STAGES flop synchronizer. If the synchronized flag is 0 on any cycle of a window, the result is a failure. A failure drives `warn_n` to 0 after the closing edge.
- R5: After a window closes, the next periodic window opens at the edge that sees the INTERVAL_S-th `sec_tick`. The interval count restarts from zero at every window, including the power-up one.
- R6: A periodic test that passes leaves `warn_n` at 0 if it was already 0. A periodic test that fails sets it to 0.
- R7: A power-up test runs even when the warning is active. Its result replaces the warning: a pass sets `warn_n` to 1 and a failure sets it to 0.
- R8: While `pwr_fail` is 1, `load_en` is 0 in that same cycle. An interrupted window commits nothing, so `warn_n` keeps its value. Ticks during the failure do not start tests.
- R9: `warn_n` changes only on the edge that closes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| rec_done | input | 1 | Supervisor: recovery time after supply-valid elapsed |
| pwr_fail | input | 1 | Supervisor: supply out of tolerance |
| batt_above_trip | input | 1 | Asynchronous comparator flag, 1 = battery above trip point |
| load_en | output | 1 | Connects the test load to the battery |
| warn_n | output | 1 | Battery warning, 0 = pull low, 1 = released |

## Verification
A wrong window counter shows up at the ports as a `load_en` pulse that lasts one tick too long or too short. A wrong interval counter shows up as a periodic test that opens one tick early or late, visible within a single interval. A wrong result latch or power-up flag shows up as a `warn_n` value that differs after the closing edge of the very window that set it. A periodic pass that wrongly clears the warning, or a power-up pass that wrongly keeps it, is caught at that edge. An abort that leaks into the result is seen when `warn_n` moves on a power failure.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_IDLE = 2'd1,
    ST_LOAD = 2'd2
  } bts_state_t;
endpackage

// File: rtl/bts_sync.sv
module bts_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bts_tick_counter.sv
module bts_tick_counter #(
  parameter int LIMIT = 86400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic at_last
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (tick) begin
      if (cnt == LAST)       cnt <= '0;
      else                   cnt <= cnt + 1'b1;
    end
  end

  assign at_last = (cnt == LAST);
endmodule

// File: rtl/bts_ctrl.sv
module bts_ctrl
  import bts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       rec_done,
  input  logic       pwr_fail,
  input  logic       ok_sync,
  input  logic       gap_last,
  input  logic       win_last,
  output bts_state_t state,
  output logic       pu_test,
  output logic       warn_q
);
  logic active;
  logic fail_q;
  logic fail_now;
  logic close_win;

  assign active    = rec_done & ~pwr_fail;
  assign fail_now  = fail_q | ~ok_sync;
  assign close_win = (state == ST_LOAD) & sec_tick & win_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      pu_test <= 1'b0;
      fail_q  <= 1'b0;
      warn_q  <= 1'b0;
    end else if (!active) begin
      state   <= ST_OFF;
      fail_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_OFF: begin
          state   <= ST_LOAD;
          pu_test <= 1'b1;
          fail_q  <= 1'b0;
        end
        ST_IDLE: begin
          if (sec_tick && gap_last) begin
            state   <= ST_LOAD;
            pu_test <= 1'b0;
            fail_q  <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (close_win) begin
            state  <= ST_IDLE;
            fail_q <= 1'b0;
            warn_q <= pu_test ? fail_now : (warn_q | fail_now);
          end else begin
            fail_q <= fail_now;
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/batt_test_sched.sv
module batt_test_sched
  import bts_pkg::*;
#(
  parameter int INTERVAL_S  = 86400,
  parameter int PULSE_S     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic rec_done,
  input  logic pwr_fail,
  input  logic batt_above_trip,
  output logic load_en,
  output logic warn_n
);
  bts_state_t ctl_state;
  logic       pu_test;
  logic       warn_q;
  logic       ok_sync;
  logic       gap_last;
  logic       win_last;

  bts_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(batt_above_trip), .q_sync(ok_sync)
  );

  bts_tick_counter #(.LIMIT(INTERVAL_S)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(ctl_state != ST_IDLE),
    .tick(sec_tick), .at_last(gap_last)
  );

  bts_tick_counter #(.LIMIT(PULSE_S)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(ctl_state != ST_LOAD),
    .tick(sec_tick), .at_last(win_last)
  );

  bts_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .rec_done(rec_done),
    .pwr_fail(pwr_fail), .ok_sync(ok_sync), .gap_last(gap_last),
    .win_last(win_last), .state(ctl_state), .pu_test(pu_test), .warn_q(warn_q)
  );

  assign load_en = (ctl_state == ST_LOAD) & ~pwr_fail;
  assign warn_n  = ~warn_q;
endmodule

// File: rtl/batt_test_sched_chk.sv
module batt_test_sched_chk
  import bts_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       rec_done,
  input logic       pwr_fail,
  input logic       load_en,
  input logic       warn_n,
  input bts_state_t state,
  input logic       pu_test
);
  a_r9_warn_moves_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(warn_n) |-> ($past(load_en) && $past(sec_tick)));

  a_r7_clear_only_powerup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_n) |-> $past(pu_test));

  a_r5_periodic_open_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && $past(state) == ST_IDLE) |-> $past(sec_tick));

  a_r3_close_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $past(state) == ST_LOAD) |-> $past(sec_tick));

  a_r8_fail_suspends: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (state == ST_OFF));

  a_r2_no_run_unrecovered: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_done |=> !load_en);
endmodule

bind batt_test_sched batt_test_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .rec_done(rec_done),
  .pwr_fail(pwr_fail), .load_en(load_en), .warn_n(warn_n),
  .state(ctl_state), .pu_test(pu_test)
);

// File: tb/tb_batt_test_sched.sv
`timescale 1ns/1ps
module tb_batt_test_sched;
  localparam int INTERVAL_S = 5;
  localparam int PULSE_S    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic rec_done = 1'b0;
  logic pwr_fail = 1'b0;
  logic batt_above_trip = 1'b1;
  logic load_en, warn_n;

  int checks = 0;
  int errors = 0;
  bit exp_warn = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  batt_test_sched #(.INTERVAL_S(INTERVAL_S), .PULSE_S(PULSE_S), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .rec_done(rec_done),
    .pwr_fail(pwr_fail), .batt_above_trip(batt_above_trip),
    .load_en(load_en), .warn_n(warn_n)
  );

  function automatic bit next_warn(bit prev, bit powerup, bit failed);
    return powerup ? failed : (prev | failed);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick();
    sec_tick = 1'b1; step(); sec_tick = 1'b0;
    repeat (1 + $urandom_range(0, 2)) step();
  endtask

  task automatic set_ok(bit ok);
    batt_above_trip = ok;
    repeat (3) step();
  endtask

  task automatic run_window(bit powerup, bit ok, string req);
    chk({req, " window open"}, load_en, 1'b1);
    repeat (2) step();
    batt_above_trip = ok;
    repeat (3) step();
    for (int i = 0; i < PULSE_S - 1; i++) tick();
    chk("R3 load held before last tick", load_en, 1'b1);
    tick();
    chk("R3 load off after last tick", load_en, 1'b0);
    exp_warn = next_warn(exp_warn, powerup, !ok);
    chk(req, warn_n, !exp_warn);
    set_ok(1'b1);
  endtask

  task automatic power_up(bit ok, string req);
    set_ok(ok);
    rec_done = 1'b1; step();
    run_window(1'b1, ok, req);
  endtask

  task automatic periodic(bit ok, string req);
    for (int i = 0; i < INTERVAL_S - 1; i++) tick();
    chk("R5 no test before interval", load_en, 1'b0);
    sec_tick = 1'b1; step(); sec_tick = 1'b0;
    run_window(1'b0, ok, req);
  endtask

  task automatic power_loss();
    pwr_fail = 1'b1; rec_done = 1'b0; #1;
    repeat (3) tick();
    chk("R8 no test while failed", load_en, 1'b0);
    chk("R8 warn held while failed", warn_n, !exp_warn);
    pwr_fail = 1'b0; step();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    chk("R1 load after reset", load_en, 1'b0);
    chk("R1 warn after reset", warn_n, 1'b1);
    rst_n = 1'b1; step();

    repeat (4) tick();
    chk("R2 no test before recovery", load_en, 1'b0);

    power_up(1'b1, "R2 R7 power-up pass");
    periodic(1'b0, "R4 periodic fail sets warn");
    periodic(1'b1, "R6 periodic pass keeps warn");

    // abort during window: load dropped combinationally, warn untouched
    for (int i = 0; i < INTERVAL_S; i++) tick();
    chk("R5 periodic window opens", load_en, 1'b1);
    batt_above_trip = 1'b1;
    pwr_fail = 1'b1; #1;
    chk("R8 load drops at once", load_en, 1'b0);
    pwr_fail = 1'b0;
    power_loss();

    power_up(1'b0, "R7 power-up fail keeps warn");
    power_loss();
    power_up(1'b1, "R7 power-up pass clears warn");
    periodic(1'b1, "R6 periodic pass stays clear");

    for (int n = 0; n < 30; n++) begin
      bit ok = bit'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) begin
        power_loss();
        power_up(ok, "R7 random power-up");
      end else begin
        periodic(ok, "R6 random periodic");
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule